// File: doc/BRIEF.md
# Byte-wide GPIO port with per-pin direction control

This block is an 8-bit general-purpose I/O port. It has two registers on a simple byte-wide register bus: a data latch and a direction register. When a pin's direction bit is 1, the pad is enabled and driven from the latch. When the bit is 0, the pin is an input. Its level passes through a two-flop synchronizer and software reads it back through the data register.

The two lowest pins also serve as interrupt request inputs, so they can never be outputs. Their direction bits are hard-wired to zero. Reads of the data register pick a source for each bit: a bit set as an output returns the latch, and a bit set as an input returns the synchronized pin.

The direction register can leave the address map. This happens in peripheral mode, and in expanded mode while the external-mode enable is set. While the register is unmapped, its writes are dropped, reads at its offset return zero, and no pad is enabled.

Top module: `gpio_dir_port`

## Requirements
- R1: After reset, the data latch and the direction register both read 0x00 and every output enable is 0.
- R2: The direction register sits at offset 0x09. Bits 7..2 are read/write, and a write takes effect on the clock edge that samples the strobe. Bits 1..0 always read 0 and ignore writes.
- R3: While the direction register is mapped, oe_o[i] equals direction bit i for bits 7..2. oe_o[1:0] is always 0.
- R4: The data latch sits at offset 0x08. A write takes effect on the clock edge that samples the strobe, and pin_o always carries the latch value.
- R5: A read at offset 0x08 returns, for each bit, the latch bit if the direction bit is 1, and the synchronized pin if it is 0. Bits 1..0 therefore always return the pin.
- R6: While periph_mode_i is 1, a read at 0x09 returns 0x00, writes to 0x09 leave the register unchanged, and oe_o is 0x00.
- R7: While expanded_i and ext_en_i are both 1, the direction register is unmapped as in R6. expanded_i alone leaves it mapped.
- R8: The data latch accepts writes while its pins are inputs. The preloaded value then appears on pins that become outputs, with no intermediate value.
- R9: A change on pin_i is not visible in data reads after one clock edge, and is visible after the second.
- R10: Any other offset reads 0x00, and writes to it change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Register byte offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| periph_mode_i | input | 1 | Peripheral mode; unmaps the direction register |
| expanded_i | input | 1 | Expanded bus mode |
| ext_en_i | input | 1 | External-mode enable; with expanded_i, unmaps the direction register |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output data |
| oe_o | output | 8 | Pad output enables |

## Verification
- Reads are combinational from the address. Register writes show on the first edge after the strobe is presented.
- Pin inputs need two edges before they appear on reads.
- The driver presents each stimulus at a falling edge and queues the expected value at that moment. The monitor compares one nanosecond after the next rising edge, so write results are checked one edge late, and read results are checked while the address is still held.
- For synchronizer latency, the driver queues the old pin value for the first edge and the new value for the second edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DATA_OFS = 8;
  localparam int unsigned DIR_OFS  = 9;

  function automatic logic dir_visible(input logic periph, input logic expd, input logic ext);
    return !periph && !(expd && ext);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[g] <= '0;
      else if (g == 0) st_q[g] <= d_i;
      else st_q[g] <= st_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = st_q[STAGES-1];

  // R9
  sync_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[0] == $past(d_i) || $past(!rst_ni));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned IN_ONLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              dir_map_i,
  output logic [W-1:0]      data_q_o,
  output logic [W-1:0]      dir_q_o
);
  localparam logic [W-1:0] DIR_MASK = {{(W-IN_ONLY){1'b1}}, {IN_ONLY{1'b0}}};

  logic data_wr, dir_wr;
  assign data_wr = we_i && (addr_i == ADDR_W'(DATA_OFS));
  assign dir_wr  = we_i && (addr_i == ADDR_W'(DIR_OFS)) && dir_map_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q_o <= '0;
      dir_q_o  <= '0;
    end else begin
      if (data_wr) data_q_o <= wdata_i;
      if (dir_wr)  dir_q_o  <= wdata_i & DIR_MASK;
    end
  end

  // R4
  data_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(DATA_OFS)) |=> data_q_o == $past(wdata_i));
  // R2
  dir_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'(DIR_OFS) && dir_map_i) |=> dir_q_o == ($past(wdata_i) & DIR_MASK));
  // R6
  dir_unmapped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_map_i) |=> $stable(dir_q_o));
endmodule

// File: rtl/gpio_dir_port.sv
module gpio_dir_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned IN_ONLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              periph_mode_i,
  input  logic              expanded_i,
  input  logic              ext_en_i,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      oe_o
);
  logic         dir_map;
  logic [W-1:0] data_q, dir_q, pin_s;

  assign dir_map = dir_visible(periph_mode_i, expanded_i, ext_en_i);

  gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  gpio_port_regs #(.W(W), .IN_ONLY(IN_ONLY)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .dir_map_i(dir_map), .data_q_o(data_q), .dir_q_o(dir_q)
  );

  // interrupt-capable low pins are never enabled
  for (genvar i = 0; i < W; i++) begin : g_oe
    if (i < IN_ONLY) begin : g_in
      assign oe_o[i] = 1'b0;
    end else begin : g_io
      assign oe_o[i] = dir_q[i] && dir_map;
    end
  end

  assign pin_o = data_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(DATA_OFS))               rdata_o = (data_q & dir_q) | (pin_s & ~dir_q);
    else if (addr_i == ADDR_W'(DIR_OFS) && dir_map) rdata_o = dir_q;
  end

  // R3
  low_pins_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o[IN_ONLY-1:0] == '0);
  // R6
  unmapped_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (periph_mode_i || (expanded_i && ext_en_i)) |-> oe_o == '0);
  // R10
  other_addr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != ADDR_W'(DATA_OFS) && addr_i != ADDR_W'(DIR_OFS)) |-> rdata_o == '0);
endmodule

// File: tb/tb_gpio_dir_port.sv
module tb_gpio_dir_port;
  localparam logic [3:0] A_DATA = 4'h8;
  localparam logic [3:0] A_DIR  = 4'h9;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o, pin_i = '0, pin_o, oe_o;
  logic       periph_mode_i = 1'b0, expanded_i = 1'b0, ext_en_i = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_dir_port dut (.*);

  typedef struct {string tag; int kind; logic [7:0] exp;} item_t;
  item_t sb_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  // monitor
  initial forever begin
    @(posedge clk_i); #1;
    while (sb_q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? rdata_o : (it.kind == 1) ? oe_o : pin_o;
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(string tag, int kind, logic [7:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    sb_q.push_back(it);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk_i); addr_i = a; we_i = 1'b1; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] exp, string tag);
    @(negedge clk_i); addr_i = a; push(tag, 0, exp);
  endtask

  task automatic ex(int kind, logic [7:0] exp, string tag);
    @(negedge clk_i); push(tag, kind, exp);
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk_i); pin_i = v;
    @(negedge clk_i); @(negedge clk_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    rd(A_DIR, 8'h00, "R1 dir reset");
    rd(A_DATA, 8'h00, "R1 data reset");
    ex(1, 8'h00, "R1 oe reset");
    // R2, R3
    wr(A_DIR, 8'hFF);
    rd(A_DIR, 8'hFC, "R2 reserved bits read 0");
    ex(1, 8'hFC, "R3 oe follows dir, low pins off");
    wr(A_DIR, 8'h03);
    rd(A_DIR, 8'h00, "R2 low bits ignore write");
    ex(1, 8'h00, "R3 oe cleared");
    // R8, R4
    wr(A_DATA, 8'h5A);
    ex(2, 8'h5A, "R4 pin_o carries latch");
    ex(1, 8'h00, "R8 preload not driven");
    wr(A_DIR, 8'hF0);
    ex(1, 8'hF0, "R8 outputs enabled");
    ex(2, 8'h5A, "R8 preloaded value on pins");
    // R5
    set_pins(8'h3C);
    rd(A_DATA, 8'h5C, "R5 mixed read");
    wr(A_DIR, 8'hFC);
    rd(A_DATA, 8'h58, "R5 low pins from pad");
    set_pins(8'h03);
    rd(A_DATA, 8'h5B, "R5 low pins readable");
    // R6
    @(negedge clk_i); periph_mode_i = 1'b1;
    ex(1, 8'h00, "R6 no drive in peripheral mode");
    rd(A_DIR, 8'h00, "R6 dir unmapped read");
    wr(A_DIR, 8'h00);
    @(negedge clk_i); periph_mode_i = 1'b0;
    rd(A_DIR, 8'hFC, "R6 write ignored");
    ex(1, 8'hFC, "R6 oe restored");
    // R7
    @(negedge clk_i); expanded_i = 1'b1;
    rd(A_DIR, 8'hFC, "R7 expanded alone mapped");
    ex(1, 8'hFC, "R7 expanded alone drives");
    @(negedge clk_i); ext_en_i = 1'b1;
    rd(A_DIR, 8'h00, "R7 unmapped read");
    ex(1, 8'h00, "R7 no drive");
    wr(A_DIR, 8'h0C);
    @(negedge clk_i); ext_en_i = 1'b0; expanded_i = 1'b0;
    rd(A_DIR, 8'hFC, "R7 write ignored");
    // R10
    rd(4'h3, 8'h00, "R10 other offset reads zero");
    wr(4'h3, 8'hFF);
    rd(A_DIR, 8'hFC, "R10 dir untouched");
    rd(A_DATA, 8'h5B, "R10 data untouched");
    // R9
    wr(A_DIR, 8'h00);
    @(negedge clk_i); addr_i = A_DATA; pin_i = 8'hA5; push("R9 not after one edge", 0, 8'h03);
    @(negedge clk_i); push("R9 visible after two edges", 0, 8'hA5);
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule